// File: doc/BRIEF.md
# Run-Length Stochastic Squashing Unit

This block shapes a stochastic bit stream, one bit per accepted sample, by watching for runs of identical bits. It sits after an averaging adder in a bit-stream neuron. In forward mode it acts as a hysteretic switch. The output moves to a bit value only after that value has been seen `n` times in a row. Over a long observation window this gives a sigmoid-like mapping from input probability to output probability, and `n` sets the slope.

In backward mode the same run detector drives a different rule. When a qualifying run is present, the output takes a fair random bit supplied from outside. Otherwise the output is a constant 1. The resulting characteristic resembles the derivative of the forward curve. The random source, the adder and the value coding all live outside this block.

Samples enter and leave through valid/ready handshakes. A sample is accepted when `in_valid` and `in_ready` are both high. Its result appears in a one-deep output register one cycle later. While that result is waiting (`out_valid` high, `out_ready` low), `in_ready` is low and the result is held unchanged. The mode, run-length and random inputs are plain control pins, sampled at the accepting edge.

Top module: `runlen_squash`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the forward-mode state is 0, so a forward sample that completes no run yields output 0.
- R2: In forward mode (`mode`=0), an accepted sample that makes the current run of identical bits reach length `run_len` sets the output, and the forward state, to that sample's value.
- R3: In forward mode, an accepted sample whose run is shorter than `run_len` leaves the forward state unchanged, and the output repeats that state.
- R4: The run count restarts at 1 when an accepted bit differs from the previously accepted bit, and saturates at `run_len`, so longer runs keep qualifying. `run_len` is taken from 1 to 15 and may change between samples.
- R5: In backward mode (`mode`=1), an accepted sample that completes or continues a qualifying run produces the value of `rnd_bit` sampled with it.
- R6: In backward mode, an accepted sample without a qualifying run produces 1.
- R7: A sample accepted at one edge is visible on `out_data` with `out_valid` high after that edge (one cycle latency).
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` stays stable. `out_valid` falls after a handshake with no new sample.
- R9: The forward state updates on every accepted sample in either mode, so after a switch back to forward mode it reflects runs seen during backward mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = forward (sigmoid-like), 1 = backward (derivative-like) |
| run_len | input | 4 | Run length threshold, 1 to 15 |
| rnd_bit | input | 1 | External fair random bit |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 1 | Input stream bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 1 | Shaped output bit |

## Verification
The assertions assume that `run_len` is never 0 while a sample is accepted. A threshold of 0 would let every sample qualify and is outside the legal range. The stimulus only draws `run_len` from 1 to 15. Runs are built with lengths both below and above each threshold. Valid gaps and ready stalls are interleaved, so every hold, switch and substitution rule is exercised.

// File: rtl/runlen_pkg.sv
package runlen_pkg;
  typedef enum logic {
    MODE_FWD = 1'b0,
    MODE_BWD = 1'b1
  } shape_mode_e;
endpackage

// File: rtl/runlen_counter.sv
module runlen_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          bit_in,
  input  logic [CW-1:0] thresh,
  output logic          run_hit,
  output logic [CW-1:0] cnt_q,
  output logic          prev_q
);
  logic [CW-1:0] cnt_next;
  logic          same;

  // a zero count means nothing has been accepted since reset
  assign same = (cnt_q != '0) && (bit_in == prev_q);

  always_comb begin
    if (!same)                 cnt_next = CW'(1);
    else if (cnt_q >= thresh)  cnt_next = thresh;
    else                       cnt_next = cnt_q + CW'(1);
  end

  assign run_hit = (cnt_next >= thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_next;
      prev_q <= bit_in;
    end
  end
endmodule

// File: rtl/runlen_shaper.sv
module runlen_shaper
  import runlen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  shape_mode_e mode,
  input  logic        bit_in,
  input  logic        run_hit,
  input  logic        rnd,
  input  logic        drain,
  output logic        fwd_q,
  output logic        valid_q,
  output logic        data_q
);
  logic fwd_next;
  logic res;

  assign fwd_next = run_hit ? bit_in : fwd_q;

  always_comb begin
    case (mode)
      MODE_BWD: res = run_hit ? rnd : 1'b1;
      default:  res = fwd_next;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= 1'b0;
    end else if (take) begin
      fwd_q   <= fwd_next;
      valid_q <= 1'b1;
      data_q  <= res;
    end else if (drain) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/runlen_squash.sv
module runlen_squash
  import runlen_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [CW-1:0] run_len,
  input  logic          rnd_bit,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_data
);
  logic          take;
  logic          run_hit;
  logic [CW-1:0] run_cnt;
  logic          prev_bit;
  logic          fwd_state;
  shape_mode_e   mode_e;

  assign mode_e   = shape_mode_e'(mode);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  runlen_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .bit_in (in_data),
    .thresh (run_len),
    .run_hit(run_hit),
    .cnt_q  (run_cnt),
    .prev_q (prev_bit)
  );

  runlen_shaper u_shp (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .mode   (mode_e),
    .bit_in (in_data),
    .run_hit(run_hit),
    .rnd    (rnd_bit),
    .drain  (out_ready),
    .fwd_q  (fwd_state),
    .valid_q(out_valid),
    .data_q (out_data)
  );
endmodule

// File: rtl/runlen_squash_chk.sv
module runlen_squash_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic [CW-1:0] run_len,
  input logic          rnd_bit,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_data,
  input logic          run_hit,
  input logic [CW-1:0] run_cnt,
  input logic          prev_bit,
  input logic          fwd_state
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_fwd_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode && run_hit) |=> (out_data == $past(in_data)));

  assert_fwd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode && !run_hit) |=> (out_data == $past(fwd_state)));

  assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && run_cnt != '0 && in_data != prev_bit) |=> (run_cnt == CW'(1)));

  assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && run_len != '0) |=> (run_cnt <= $past(run_len)));

  assert_bwd_rand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode && run_hit) |=> (out_data == $past(rnd_bit)));

  assert_bwd_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode && !run_hit) |=> out_data);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_fwd_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode && run_hit) |=> (fwd_state == $past(in_data)));
endmodule

bind runlen_squash runlen_squash_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .run_len  (run_len),
  .rnd_bit  (rnd_bit),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .run_hit  (run_hit),
  .run_cnt  (run_cnt),
  .prev_bit (prev_bit),
  .fwd_state(fwd_state)
);

// File: tb/runlen_squash_tb.sv
module runlen_squash_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] run_len = 4'd1;
  logic       rnd_bit = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_data = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic       out_valid;
  logic       out_data;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  int   m_cnt = 0;
  logic m_prev = 1'b0;
  logic m_fwd = 1'b0;
  logic ev = 1'b0;
  logic ed = 1'b0;
  string etag = "R1";

  logic [15:0] lfsr = 16'hACE1;
  int   run_left = 0;
  logic run_bit = 1'b0;

  always #5 clk = ~clk;

  runlen_squash u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run_len(run_len),
    .rnd_bit(rnd_bit), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check result of last edge, then drive and advance model
  task automatic cycle(input logic v, input logic b, input logic rdy);
    logic acc, same, hit;
    check("R7 out_valid", out_valid, ev);
    if (ev) check({etag, " out_data"}, out_data, ed);
    in_valid  = v;
    in_data   = b;
    out_ready = rdy;
    lfsr      = step(lfsr);
    rnd_bit   = lfsr[0];
    #1;
    check("R8 in_ready", in_ready, !ev || rdy);
    acc = v && (!ev || rdy);
    if (acc) begin
      same = (m_cnt != 0) && (b == m_prev);
      if (!same) m_cnt = 1;
      else if (m_cnt >= int'(run_len)) m_cnt = int'(run_len);
      else m_cnt = m_cnt + 1;
      hit = (m_cnt >= int'(run_len));
      m_prev = b;
      if (hit) m_fwd = b;
      if (mode) begin
        ed   = hit ? rnd_bit : 1'b1;
        etag = hit ? "R5" : "R6";
      end else begin
        ed   = m_fwd;
        etag = hit ? "R2" : "R3";
      end
      ev = 1'b1;
    end else if (rdy) begin
      ev = 1'b0;
    end
    @(negedge clk);
  endtask

  // stream bits in runs of random length 1..8
  task automatic stream(input int cycles, input bit stalls);
    logic v, rdy;
    for (int i = 0; i < cycles; i++) begin
      if (run_left == 0) begin
        lfsr = step(lfsr);
        run_left = int'(lfsr[3:1]) + 1;
        run_bit = ~run_bit;
      end
      lfsr = step(lfsr);
      v   = stalls ? (lfsr[2:0] != 3'd0) : 1'b1;
      rdy = stalls ? (lfsr[5:4] != 2'd0) : 1'b1;
      cycle(v, run_bit, rdy);
      if (v && (!ev || rdy)) run_left--;
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 out_valid", out_valid, 1'b0);
        check("R1 in_ready", in_ready, 1'b1);
        @(negedge clk);
        // R1: n=3, single 1 completes no run -> forward state 0
        mode = 1'b0; run_len = 4'd3;
        cycle(1'b1, 1'b1, 1'b1);
        check("R1 first out", out_data, 1'b0);
        // R4: saturate at 15 needs a long run
        run_len = 4'd15;
        for (int k = 0; k < 20; k++) cycle(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 14; k++) cycle(1'b1, 1'b1, 1'b1);
        check("R4 below 15", out_data, 1'b0);
        cycle(1'b1, 1'b1, 1'b1);
        check("R4 at 15", out_data, 1'b1);
        // sweep thresholds and both modes, without and with stalls (R9 across mode switches)
        for (int n = 1; n <= 15; n++) begin
          for (int md = 0; md < 2; md++) begin
            run_len = 4'(n);
            mode = md[0];
            stream(150, 1'b0);
            stream(150, 1'b1);
          end
        end
        // drain
        cycle(1'b0, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b1);
        check("R8 drained", out_valid, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_any
  end
endmodule